// File: doc/BRIEF.md
# SMBus Slave Address Filter

This block decides whether the local SMBus port claims an incoming transaction. A bit-level front end, which is not part of this block, reports bus events as single-cycle strobes. These are a start condition, a stop condition, a loss of arbitration by the local master during its first byte, and each completed received byte. After a start, or after such an arbitration loss, the block waits for the first byte of the transfer.

The first byte is checked against two programmable 7-bit slave addresses. It can also be checked against the all-zero address when that match is enabled. A claimed byte is acknowledged and pushed toward the receive FIFO. Its direction bit is held as a read-request flag, so that firmware knows it must supply data. When filtering is switched off, every first byte is claimed.

An unclaimed transfer is ignored until the bus is released. Later bytes of a claimed write are acknowledged and forwarded. Later bytes of a claimed read come from the local side and are not pushed.

Top module: `smb_addr_filter`

## Requirements
- R1: After reset, `ack`, `fifo_push`, `read_req` and `slave_active` are all 0.
- R2: A start strobe (`bus_start`) opens the address phase. A byte strobe arriving while no transfer is open causes no `ack` and no `fifo_push`.
- R3: A first-byte arbitration-loss strobe (`arb_lost_first`) opens the address phase in the same way as a start.
- R4: In the address phase with filtering on, a byte whose bits [7:1] equal `cfg_addr_a` is claimed. In the cycle after the byte strobe, `ack` and `fifo_push` are 1 for one cycle and `fifo_data` equals the byte. From then on, `slave_active` is 1.
- R5: A first byte whose bits [7:1] equal `cfg_addr_b` is claimed in the same way.
- R6: A first byte with bits [7:1] equal to 0 is claimed only when `cfg_zero_en` is 1, unless it matches a programmed address.
- R7: With `cfg_filter_en` at 0, every first byte is claimed, whatever its value.
- R8: Bit 0 of a claimed first byte appears on `read_req` (1 = read, 0 = write) in the cycle after the byte strobe. It stays there while the transfer is claimed. `read_req` is never 1 unless `slave_active` is 1.
- R9: A first byte that does not match gives no `ack`. All further bytes are then ignored until a stop, and after that stop a new start is filtered normally.
- R10: While claimed for a write, each later byte is acknowledged and pushed, with `fifo_data` equal to that byte. While claimed for a read, later bytes give no `ack` and no `fifo_push`.
- R11: A stop strobe returns the block to idle, clearing `slave_active` and `read_req` in the next cycle. A stop takes priority over a start given in the same cycle, and a byte strobe given in that cycle is discarded.
- R12: A start given while claimed (a repeated start) reopens the address phase. `slave_active` and `read_req` clear, and the next byte is filtered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Start or repeated-start condition seen (one-cycle strobe) |
| bus_stop | input | 1 | Stop condition seen (one-cycle strobe) |
| arb_lost_first | input | 1 | Local master lost arbitration during its first byte (strobe) |
| byte_valid | input | 1 | A received byte is complete on `byte_data` (strobe) |
| byte_data | input | 8 | Received byte: [7:1] address or data, [0] direction on the first byte |
| cfg_filter_en | input | 1 | 1 = compare addresses, 0 = claim every first byte |
| cfg_zero_en | input | 1 | 1 = address 0 is also claimed |
| cfg_addr_a | input | 7 | First programmable slave address |
| cfg_addr_b | input | 7 | Second programmable slave address |
| ack | output | 1 | Acknowledge the byte seen in the previous cycle (one-cycle pulse) |
| fifo_push | output | 1 | Write `fifo_data` into the receive FIFO (one-cycle pulse) |
| fifo_data | output | 8 | Byte forwarded to the receive FIFO |
| read_req | output | 1 | The claimed transfer is a read |
| slave_active | output | 1 | A transfer is currently claimed |

## Verification
A wrong sequencer state shows up within one cycle of the next byte strobe. A stuck idle or ignore state drops an `ack` that should have been given. A stuck claimed state acknowledges traffic that belongs to another device, or keeps `slave_active` high after a stop. A faulty comparator slot or zero-address gate flips `ack` for the single first byte that exercises it, so the stimulus table aims one byte at each slot, at address zero in both gate settings, and at a near miss. A corrupted direction bit shows on `read_req` in the same cycle as `ack`. It then shows again on the following byte, which is pushed when it should be held back, or the reverse.

// File: rtl/smb_filt_pkg.sv
package smb_filt_pkg;

  localparam int unsigned SMB_ADDR_W = 7;
  localparam int unsigned SMB_BYTE_W = SMB_ADDR_W + 1;

  typedef enum logic [1:0] {
    SL_IDLE  = 2'd0,
    SL_ADDR  = 2'd1,
    SL_CLAIM = 2'd2,
    SL_SKIP  = 2'd3
  } slv_state_t;

  // One comparator slot: exact match of the 7-bit address field.
  function automatic logic slot_hit(input logic [SMB_ADDR_W-1:0] rx_addr,
                                    input logic [SMB_ADDR_W-1:0] slot_addr);
    return (rx_addr == slot_addr);
  endfunction

  // Zero-address rule: only counts when its enable is set.
  function automatic logic zero_hit(input logic [SMB_ADDR_W-1:0] rx_addr,
                                    input logic                  zero_en);
    return zero_en && (rx_addr == '0);
  endfunction

endpackage

// File: rtl/smb_addr_match.sv
module smb_addr_match
  import smb_filt_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2
) (
  input  logic [SMB_ADDR_W-1:0]           rx_addr,
  input  logic [NUM_SLOTS*SMB_ADDR_W-1:0] slot_addrs,
  input  logic                            filter_en,
  input  logic                            zero_en,
  output logic                            hit
);

  logic [NUM_SLOTS-1:0] slot_match;
  logic                 any_slot;
  logic                 zero_match;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_match[s] = slot_hit(rx_addr, slot_addrs[s*SMB_ADDR_W +: SMB_ADDR_W]);
  end

  assign any_slot   = |slot_match;
  assign zero_match = zero_hit(rx_addr, zero_en);
  assign hit        = !filter_en || any_slot || zero_match;

endmodule

// File: rtl/smb_slave_seq.sv
module smb_slave_seq
  import smb_filt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       arb_lost_first,
  input  logic       byte_valid,
  input  logic       dir_bit,
  input  logic       addr_hit,
  output slv_state_t state,
  output logic       addr_take,
  output logic       data_take,
  output logic       rd_dir
);

  slv_state_t state_d;
  logic       frame_evt;
  logic       byte_evt;
  logic       rd_d;

  // Framing strobes override any byte seen in the same cycle.
  assign frame_evt = bus_stop || bus_start || arb_lost_first;
  assign byte_evt  = byte_valid && !frame_evt;

  assign addr_take = byte_evt && (state == SL_ADDR) && addr_hit;
  assign data_take = byte_evt && (state == SL_CLAIM) && !rd_dir;

  always_comb begin
    state_d = state;
    if (bus_stop) begin
      state_d = SL_IDLE;
    end else if (bus_start || arb_lost_first) begin
      state_d = SL_ADDR;
    end else if (byte_evt && state == SL_ADDR) begin
      state_d = addr_hit ? SL_CLAIM : SL_SKIP;
    end
  end

  always_comb begin
    rd_d = 1'b0;
    if (state_d == SL_CLAIM) begin
      rd_d = addr_take ? dir_bit : rd_dir;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SL_IDLE;
      rd_dir <= 1'b0;
    end else begin
      state  <= state_d;
      rd_dir <= rd_d;
    end
  end

  // A claim is only ever reached from the address phase.
  assert_claim_from_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SL_CLAIM && $past(state) != SL_CLAIM) |-> $past(state) == SL_ADDR);

  // An ignored transfer stays ignored until a framing strobe.
  assert_skip_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SL_SKIP && !bus_stop && !bus_start && !arb_lost_first) |=> state == SL_SKIP);

endmodule

// File: rtl/smb_rx_out.sv
module smb_rx_out
  import smb_filt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_take,
  input  logic                  data_take,
  input  logic [SMB_BYTE_W-1:0] byte_in,
  output logic                  ack,
  output logic                  fifo_push,
  output logic [SMB_BYTE_W-1:0] fifo_data
);

  logic take;

  assign take = addr_take || data_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack       <= 1'b0;
      fifo_push <= 1'b0;
      fifo_data <= '0;
    end else begin
      ack       <= take;
      fifo_push <= take;
      if (take) begin
        fifo_data <= byte_in;
      end
    end
  end

endmodule

// File: rtl/smb_addr_filter.sv
module smb_addr_filter
  import smb_filt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_start,
  input  logic                  bus_stop,
  input  logic                  arb_lost_first,
  input  logic                  byte_valid,
  input  logic [SMB_BYTE_W-1:0] byte_data,
  input  logic                  cfg_filter_en,
  input  logic                  cfg_zero_en,
  input  logic [SMB_ADDR_W-1:0] cfg_addr_a,
  input  logic [SMB_ADDR_W-1:0] cfg_addr_b,
  output logic                  ack,
  output logic                  fifo_push,
  output logic [SMB_BYTE_W-1:0] fifo_data,
  output logic                  read_req,
  output logic                  slave_active
);

  localparam int unsigned NUM_SLOTS = 2;

  logic [NUM_SLOTS*SMB_ADDR_W-1:0] slots;
  logic                            hit;
  slv_state_t                      st;
  logic                            addr_take;
  logic                            data_take;
  logic                            rd_dir;

  assign slots = {cfg_addr_b, cfg_addr_a};

  smb_addr_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
    .rx_addr    (byte_data[SMB_BYTE_W-1:1]),
    .slot_addrs (slots),
    .filter_en  (cfg_filter_en),
    .zero_en    (cfg_zero_en),
    .hit        (hit)
  );

  smb_slave_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_start      (bus_start),
    .bus_stop       (bus_stop),
    .arb_lost_first (arb_lost_first),
    .byte_valid     (byte_valid),
    .dir_bit        (byte_data[0]),
    .addr_hit       (hit),
    .state          (st),
    .addr_take      (addr_take),
    .data_take      (data_take),
    .rd_dir         (rd_dir)
  );

  smb_rx_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_take (addr_take),
    .data_take (data_take),
    .byte_in   (byte_data),
    .ack       (ack),
    .fifo_push (fifo_push),
    .fifo_data (fifo_data)
  );

  assign slave_active = (st == SL_CLAIM);
  assign read_req     = rd_dir;

  assert_ack_after_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(byte_valid));

  assert_zero_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_filter_en && !cfg_zero_en && byte_data[SMB_BYTE_W-1:1] == '0 &&
     cfg_addr_a != '0 && cfg_addr_b != '0) |-> !hit);

  assert_read_in_claim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    read_req |-> slave_active);

  assert_skip_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SL_SKIP && byte_valid) |=> !ack);

  assert_read_no_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_active && read_req && byte_valid) |=> !fifo_push);

  assert_stop_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (!slave_active && !read_req));

endmodule

// File: tb/smb_addr_filter_test.sv
module smb_addr_filter_test;

  localparam int CLK_P = 10;
  localparam logic [6:0] ADDR_A = 7'h2A;
  localparam logic [6:0] ADDR_B = 7'h51;
  localparam int NV = 8;
  // {filter_en, zero_en, first_byte[7:0], exp_ack, exp_read}
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h54, 1'b1, 1'b0},  // R4 slot A write
    {1'b1, 1'b0, 8'hA3, 1'b1, 1'b1},  // R5 slot B read
    {1'b1, 1'b0, 8'h00, 1'b0, 1'b0},  // R6 zero, gate off
    {1'b1, 1'b1, 8'h01, 1'b1, 1'b1},  // R6 zero, gate on
    {1'b1, 1'b0, 8'h56, 1'b0, 1'b0},  // R9 near miss
    {1'b0, 1'b0, 8'h56, 1'b1, 1'b0},  // R7 bypass
    {1'b0, 1'b0, 8'hFF, 1'b1, 1'b1},  // R7 bypass read
    {1'b1, 1'b1, 8'h55, 1'b1, 1'b1}   // R8 slot A read
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_start = 1'b0, bus_stop = 1'b0, arb_lost_first = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       cfg_filter_en = 1'b1, cfg_zero_en = 1'b0;
  logic [6:0] cfg_addr_a = ADDR_A, cfg_addr_b = ADDR_B;
  logic       ack, fifo_push, read_req, slave_active;
  logic [7:0] fifo_data;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  smb_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .arb_lost_first(arb_lost_first), .byte_valid(byte_valid), .byte_data(byte_data),
    .cfg_filter_en(cfg_filter_en), .cfg_zero_en(cfg_zero_en),
    .cfg_addr_a(cfg_addr_a), .cfg_addr_b(cfg_addr_b),
    .ack(ack), .fifo_push(fifo_push), .fifo_data(fifo_data),
    .read_req(read_req), .slave_active(slave_active)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Drive one cycle of strobes, then release; outputs are sampled on return.
  task automatic pulse(input logic st, input logic sp, input logic al,
                       input logic bv, input logic [7:0] d);
    @(negedge clk);
    bus_start = st; bus_stop = sp; arb_lost_first = al; byte_valid = bv; byte_data = d;
    @(negedge clk);
    bus_start = 1'b0; bus_stop = 1'b0; arb_lost_first = 1'b0; byte_valid = 1'b0;
  endtask

  task automatic check_ack(input string tag, input logic e_ack, input logic [7:0] e_data,
                           input logic e_rd);
    check({tag, " ack"}, {7'd0, ack}, {7'd0, e_ack});
    check({tag, " push"}, {7'd0, fifo_push}, {7'd0, e_ack});
    if (e_ack) check({tag, " data"}, fifo_data, e_data);
    check({tag, " read_req"}, {7'd0, read_req}, {7'd0, e_rd});
    check({tag, " active"}, {7'd0, slave_active}, {7'd0, e_ack});
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ack", {7'd0, ack}, 8'd0);
    check("R1 push", {7'd0, fifo_push}, 8'd0);
    check("R1 read_req", {7'd0, read_req}, 8'd0);
    check("R1 active", {7'd0, slave_active}, 8'd0);
    @(negedge clk) rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      cfg_filter_en = VEC[i][11];
      cfg_zero_en   = VEC[i][10];
      pulse(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
      pulse(1'b0, 1'b0, 1'b0, 1'b1, VEC[i][9:2]);
      check_ack($sformatf("R4-table vec%0d", i), VEC[i][1], VEC[i][9:2],
                VEC[i][1] & VEC[i][0]);
      pulse(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    end
    cfg_filter_en = 1'b1; cfg_zero_en = 1'b0;

    // R2 byte while idle is ignored
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 8'h54);
    check_ack("R2 idle byte", 1'b0, 8'h00, 1'b0);

    // R3 arbitration loss opens address phase
    pulse(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 8'h54);
    check_ack("R3 arb-loss claim", 1'b1, 8'h54, 1'b0);
    // R10 later write bytes forwarded
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 8'h3C);
    check_ack("R10 write data", 1'b1, 8'h3C, 1'b0);
    // R12 repeated start re-filters
    pulse(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R12 active cleared", {7'd0, slave_active}, 8'd0);
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 8'hA3);
    check_ack("R12 re-claim read", 1'b1, 8'hA3, 1'b1);
    // R10 later bytes of a read are not pushed
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 8'h77);
    check("R10 read no ack", {7'd0, ack}, 8'd0);
    check("R10 read no push", {7'd0, fifo_push}, 8'd0);
    check("R8 read held", {7'd0, read_req}, 8'd1);
    // R11 stop beats start; byte in that cycle discarded
    pulse(1'b1, 1'b1, 1'b0, 1'b1, 8'h54);
    check("R11 stop active", {7'd0, slave_active}, 8'd0);
    check("R11 stop read_req", {7'd0, read_req}, 8'd0);
    check("R11 stop no ack", {7'd0, ack}, 8'd0);
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 8'h54);
    check_ack("R11 idle after stop", 1'b0, 8'h00, 1'b0);

    // R9 no match: rest ignored until stop
    pulse(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 8'h10);
    check_ack("R9 miss", 1'b0, 8'h00, 1'b0);
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 8'h54);
    check_ack("R9 later byte ignored", 1'b0, 8'h00, 1'b0);
    pulse(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    pulse(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 8'h54);
    check_ack("R9 after stop", 1'b1, 8'h54, 1'b0);

    // R4 ack is a single-cycle pulse
    @(negedge clk);
    check("R4 ack pulse", {7'd0, ack}, 8'd0);
    pulse(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule